// File: doc/BRIEF.md
# Dirty Scanline Run Coalescer

This block turns a per-row dirty bitmap into a short list of rectangular screen update regions. A pass starts with a one-cycle start strobe, which also captures the frame height, the mode width and a full-refresh flag. In a scan pass the block first pulses a snapshot strobe. This tells the bitmap owner to capture and clear the dirty state for the whole frame in one step. The block then asks for the rows one at a time on a request/response pair, from the top row downward, and joins consecutive dirty rows into a single region.

A region is given as a first row and a row count. It always begins at column 0 and spans the whole mode width. It leaves on a valid/ready port, and while the consumer holds ready low the scan waits. A full-refresh pass skips the bitmap entirely and produces one region that covers the whole frame. Each pass ends with a one-cycle done pulse.

Top module: `dirty_run_coalescer`

## Requirements
- R1: After reset, busy, done, snapshot, row request and region valid are all low.
- R2: A scan pass with a nonzero height pulses the snapshot strobe for exactly one cycle, before its first row request. A full-refresh pass or a zero-height pass never pulses it.
- R3: A scan pass requests every row index from 0 up to height-1, in increasing order, exactly once each, and keeps at most one request outstanding.
- R4: A dirty row (response bit 1) that arrives with no run open starts a run at that row. The first clean row (response bit 0) after it closes the run and emits the region (run start, that row minus run start).
- R5: A run that is still open after the last row is emitted as (run start, height minus run start).
- R6: Every region reports column 0 and the width captured at the start of the pass.
- R7: A full-refresh pass emits exactly one region (0, height) and issues no row requests.
- R8: While region valid is high and ready is low, the region holds stable and the scan does not advance. Every region is delivered exactly once.
- R9: Done pulses for one cycle after the last region of the pass is accepted, or after the last row if no region was produced. A zero-height pass produces only the done pulse.
- R10: A start strobe that arrives while a pass is busy is ignored. It adds no region and no extra done pulse.
- R11: Every emitted region has a nonzero row count and ends at or before the captured height.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a pass when idle |
| full_i | input | 1 | With start: emit one whole-frame region, no scan |
| height_i | input | 12 | Frame height in rows, captured at start |
| width_i | input | 12 | Mode width in pixels, captured at start |
| busy_o | output | 1 | A pass is in progress |
| snap_o | output | 1 | One-cycle strobe: capture and clear dirty state |
| req_valid_o | output | 1 | Row dirty-flag request valid |
| req_ready_i | input | 1 | Bitmap owner accepts the request |
| req_row_o | output | 12 | Row index being requested |
| rsp_valid_i | input | 1 | Dirty-flag response valid |
| rsp_dirty_i | input | 1 | Response: 1 means the row is dirty |
| out_valid_o | output | 1 | Region valid |
| out_ready_i | input | 1 | Consumer accepts the region |
| out_row_o | output | 12 | First row of the region |
| out_rows_o | output | 12 | Number of rows in the region |
| out_col_o | output | 12 | First column of the region (always 0) |
| out_width_o | output | 12 | Region width in pixels |
| done_o | output | 1 | One-cycle end-of-pass pulse |

## Verification
The assertions check every cycle that a stalled region does not change, that a region is never loaded over one that is still pending, and that a region and a row request are never offered together. They also check that every region is nonempty and lies inside the frame, that the snapshot strobe leads straight into the first request, and that done lasts one cycle. Only the bench scenarios can show that run boundaries match the bitmap: runs at the top edge, at the bottom edge, alternating rows, an all-dirty frame and a clean frame. The same holds for rows being asked for in order, the full-refresh bypass, a second pass finding nothing once the snapshot cleared it, and a start strobe in mid-pass being ignored.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int unsigned ROWS_W = 12;
    localparam int unsigned COLS_W = 12;

    typedef logic [ROWS_W-1:0] row_t;
    typedef logic [COLS_W-1:0] col_t;

    typedef struct packed {
        row_t first;
        row_t count;
    } region_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNAP,
        ST_REQ,
        ST_WAIT,
        ST_DRAIN,
        ST_DONE
    } pass_state_t;

    function automatic region_t make_region(row_t first, row_t count);
        region_t r;
        r.first = first;
        r.count = count;
        return r;
    endfunction

endpackage

// File: rtl/scan_row_walker.sv
module scan_row_walker
    import scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  row_t height,
    output row_t row,
    output logic last
);
    row_t row_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= row_q + row_t'(1);
        end
    end

    assign row  = row_q;
    assign last = (row_q == height - row_t'(1));

    a_r3_step_in_range: assert property (@(posedge clk) disable iff (rst)
        step |-> !last);

endmodule

// File: rtl/scan_run_tracker.sv
module scan_run_tracker
    import scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    eval,
    input  logic    dirty,
    input  row_t    row,
    input  logic    last,
    input  row_t    height,
    output logic    emit,
    output region_t region
);
    logic open_q;
    row_t start_q;
    row_t run_first;

    assign run_first = open_q ? start_q : row;

    always_comb begin
        emit   = 1'b0;
        region = make_region('0, '0);
        if (eval) begin
            if (!dirty && open_q) begin
                emit   = 1'b1;
                region = make_region(start_q, row - start_q);
            end else if (dirty && last) begin
                emit   = 1'b1;
                region = make_region(run_first, height - run_first);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            open_q  <= 1'b0;
            start_q <= '0;
        end else if (eval) begin
            if (last || !dirty) begin
                open_q <= 1'b0;
            end else if (!open_q) begin
                open_q  <= 1'b1;
                start_q <= row;
            end
        end
    end

    a_r4_close_nonempty: assert property (@(posedge clk) disable iff (rst)
        emit |-> region.count != '0);

    a_r4_run_start_behind: assert property (@(posedge clk) disable iff (rst)
        (eval && open_q) |-> start_q < row);

endmodule

// File: rtl/scan_region_slot.sv
module scan_region_slot
    import scan_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  region_t load_region,
    input  logic    ready,
    output logic    valid,
    output logic    taken,
    output region_t region
);
    logic    valid_q;
    region_t region_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            region_q <= make_region('0, '0);
        end else if (load) begin
            valid_q  <= 1'b1;
            region_q <= load_region;
        end else if (valid_q && ready) begin
            valid_q <= 1'b0;
        end
    end

    assign valid  = valid_q;
    assign taken  = valid_q && ready;
    assign region = region_q;

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !ready) |=> (valid_q && $stable(region_q)));

    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        load |-> !valid_q);

endmodule

// File: rtl/dirty_run_coalescer.sv
module dirty_run_coalescer
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              full_i,
    input  logic [ROWS_W-1:0] height_i,
    input  logic [COLS_W-1:0] width_i,
    output logic              busy_o,
    output logic              snap_o,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ROWS_W-1:0] req_row_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_dirty_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [ROWS_W-1:0] out_row_o,
    output logic [ROWS_W-1:0] out_rows_o,
    output logic [COLS_W-1:0] out_col_o,
    output logic [COLS_W-1:0] out_width_o,
    output logic              done_o
);
    localparam int unsigned SPAN_W = ROWS_W + 1;

    pass_state_t state_q, state_d;
    row_t        height_q;
    col_t        width_q;
    logic        fin_q, fin_d;

    logic        accept_start;
    logic        walk_clear, walk_step, walk_last;
    row_t        walk_row;
    logic        eval, emit;
    region_t     run_region;
    logic        slot_load, slot_valid, slot_taken;
    region_t     slot_in, slot_region;

    assign accept_start = (state_q == ST_IDLE) && start_i;
    assign eval         = (state_q == ST_WAIT) && rsp_valid_i;
    assign walk_clear   = accept_start;

    scan_row_walker u_walker (
        .clk    (clk),
        .rst    (rst),
        .clear  (walk_clear),
        .step   (walk_step),
        .height (height_q),
        .row    (walk_row),
        .last   (walk_last)
    );

    scan_run_tracker u_tracker (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept_start),
        .eval   (eval),
        .dirty  (rsp_dirty_i),
        .row    (walk_row),
        .last   (walk_last),
        .height (height_q),
        .emit   (emit),
        .region (run_region)
    );

    scan_region_slot u_slot (
        .clk         (clk),
        .rst         (rst),
        .load        (slot_load),
        .load_region (slot_in),
        .ready       (out_ready_i),
        .valid       (slot_valid),
        .taken       (slot_taken),
        .region      (slot_region)
    );

    always_comb begin
        state_d   = state_q;
        fin_d     = fin_q;
        walk_step = 1'b0;
        slot_load = 1'b0;
        slot_in   = run_region;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (height_i == '0) begin
                        state_d = ST_DONE;
                    end else if (full_i) begin
                        slot_load = 1'b1;
                        slot_in   = make_region('0, height_i);
                        fin_d     = 1'b1;
                        state_d   = ST_DRAIN;
                    end else begin
                        state_d = ST_SNAP;
                    end
                end
            end
            ST_SNAP: state_d = ST_REQ;
            ST_REQ: begin
                if (req_ready_i) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    if (emit) begin
                        slot_load = 1'b1;
                        fin_d     = walk_last;
                        state_d   = ST_DRAIN;
                    end else if (walk_last) begin
                        state_d = ST_DONE;
                    end else begin
                        walk_step = 1'b1;
                        state_d   = ST_REQ;
                    end
                end
            end
            ST_DRAIN: begin
                if (slot_taken) begin
                    if (fin_q) begin
                        state_d = ST_DONE;
                    end else begin
                        walk_step = 1'b1;
                        state_d   = ST_REQ;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            fin_q    <= 1'b0;
            height_q <= '0;
            width_q  <= '0;
        end else begin
            state_q <= state_d;
            fin_q   <= fin_d;
            if (accept_start) begin
                height_q <= height_i;
                width_q  <= width_i;
            end
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign snap_o      = (state_q == ST_SNAP);
    assign req_valid_o = (state_q == ST_REQ);
    assign req_row_o   = walk_row;
    assign done_o      = (state_q == ST_DONE);
    assign out_valid_o = slot_valid;
    assign out_row_o   = slot_region.first;
    assign out_rows_o  = slot_region.count;
    assign out_col_o   = '0;
    assign out_width_o = width_q;

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r3_one_channel: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> !out_valid_o);

    a_r2_snap_then_req: assert property (@(posedge clk) disable iff (rst)
        snap_o |=> (req_valid_o && req_row_o == '0));

    a_r11_in_frame: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_rows_o != '0 &&
            (SPAN_W'(out_row_o) + SPAN_W'(out_rows_o)) <= SPAN_W'(height_q)));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !done_o) |=> busy_o);

endmodule

// File: tb/dirty_run_coalescer_tb_top.sv
module dirty_run_coalescer_tb_top;
    localparam int MAXH = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        full_i = 1'b0;
    logic [11:0] height_i = '0;
    logic [11:0] width_i = '0;
    logic        busy_o, snap_o, req_valid_o, out_valid_o, done_o;
    logic        req_ready_i = 1'b0;
    logic        rsp_valid_i = 1'b0;
    logic        rsp_dirty_i = 1'b0;
    logic        out_ready_i = 1'b0;
    logic [11:0] req_row_o, out_row_o, out_rows_o, out_col_o, out_width_o;

    always #10 clk = ~clk;

    dirty_run_coalescer dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .full_i(full_i),
        .height_i(height_i), .width_i(width_i), .busy_o(busy_o),
        .snap_o(snap_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .req_row_o(req_row_o), .rsp_valid_i(rsp_valid_i),
        .rsp_dirty_i(rsp_dirty_i), .out_valid_o(out_valid_o),
        .out_ready_i(out_ready_i), .out_row_o(out_row_o),
        .out_rows_o(out_rows_o), .out_col_o(out_col_o),
        .out_width_o(out_width_o), .done_o(done_o)
    );

    int compared = 0;
    int mismatched = 0;

    logic live_bits [MAXH];
    logic snap_bits [MAXH];
    int   exp_q [$];
    int   cur_w = 0;
    int   snap_seen = 0;
    int   rows_seen = 0;
    int   done_seen = 0;
    bit   heavy_stall = 0;
    bit   mon_on = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void push_expected(input int h);
        bit open = 0;
        int s = 0;
        for (int y = 0; y < h; y++) begin
            if (live_bits[y] && !open) begin open = 1; s = y; end
            else if (!live_bits[y] && open) begin
                exp_q.push_back((s << 16) | (y - s));
                open = 0;
            end
        end
        if (open) exp_q.push_back((s << 16) | (h - s));
    endfunction

    // Responder, consumer and scoreboard monitor, all at the falling edge.
    initial begin
        int pend_row = -1;
        int pend_wait = 0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rsp_valid_i = 1'b0;
            if (!mon_on) begin
                req_ready_i = 1'b0;
                out_ready_i = 1'b0;
                continue;
            end
            if (pend_row >= 0) begin
                if (pend_wait == 0) begin
                    check(pend_row == rows_seen, "R3", "row order",
                          pend_row, rows_seen);
                    rsp_valid_i = 1'b1;
                    rsp_dirty_i = snap_bits[pend_row % MAXH];
                    rows_seen++;
                    pend_row = -1;
                end else begin
                    pend_wait--;
                end
            end
            if (snap_o) begin
                snap_seen++;
                for (int i = 0; i < MAXH; i++) begin
                    snap_bits[i] = live_bits[i];
                    live_bits[i] = 1'b0;
                end
            end
            if (done_o) done_seen++;
            req_ready_i = lfsr[0] | lfsr[1];
            out_ready_i = heavy_stall ? (lfsr[4:2] == 3'd0) : (lfsr[3] | lfsr[5]);
            if (req_valid_o && req_ready_i) begin
                check(pend_row < 0, "R3", "single outstanding", pend_row, -1);
                pend_row  = int'(req_row_o);
                pend_wait = int'(lfsr[7:6]) % 3;
            end
            if (out_valid_o && out_ready_i) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unexpected region row", int'(out_row_o), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(out_row_o) == (e >> 16), "R4", "region first row",
                          int'(out_row_o), e >> 16);
                    check(int'(out_rows_o) == (e & 16'hFFFF), "R5", "region row count",
                          int'(out_rows_o), e & 16'hFFFF);
                end
                check(out_col_o == '0 && int'(out_width_o) == cur_w, "R6",
                      "region column/width", int'(out_width_o), cur_w);
            end
        end
    end

    task automatic run_pass(input int h, input int w, input bit full,
                            input bit inject, input string tag);
        bit scan;
        int waited = 0;
        scan = !full && h > 0;
        exp_q.delete();
        if (full && h > 0) exp_q.push_back(h);
        else if (scan) push_expected(h);
        snap_seen = 0; rows_seen = 0; done_seen = 0; cur_w = w;
        @(negedge clk);
        height_i = 12'(h); width_i = 12'(w); full_i = full; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; full_i = 1'b0;
        if (inject) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; full_i = 1'b1; height_i = 12'd5;
            @(negedge clk);
            start_i = 1'b0; full_i = 1'b0;
        end
        while (done_seen == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        check(done_seen == 1, "R9", {tag, " done pulses"}, done_seen, 1);
        check(exp_q.size() == 0, "R8", {tag, " regions left"}, exp_q.size(), 0);
        check(snap_seen == (scan ? 1 : 0), "R2", {tag, " snapshots"},
              snap_seen, scan ? 1 : 0);
        check(rows_seen == (scan ? h : 0), full ? "R7" : "R3",
              {tag, " rows requested"}, rows_seen, scan ? h : 0);
        check(!busy_o, "R10", {tag, " idle after"}, busy_o, 0);
    endtask

    task automatic set_bits(input int h, input int pattern);
        for (int i = 0; i < MAXH; i++) live_bits[i] = 1'b0;
        for (int i = 0; i < h; i++) begin
            case (pattern)
                0: live_bits[i] = 1'b0;
                1: live_bits[i] = 1'b1;
                2: live_bits[i] = i[0];
                3: live_bits[i] = (i < 3) || (i >= h - 4) || (i >= 20 && i < 27);
                default: live_bits[i] = ((i * 7) % 5) < 2;
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < MAXH; i++) begin live_bits[i] = 0; snap_bits[i] = 0; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!busy_o && !done_o && !snap_o && !req_valid_o && !out_valid_o,
              "R1", "reset outputs", {busy_o, done_o, snap_o, req_valid_o, out_valid_o}, 0);
        mon_on = 1;

        // R4: mixed runs, including one that begins on row 0
        for (int i = 0; i < MAXH; i++) live_bits[i] = 0;
        live_bits[0] = 1; live_bits[1] = 1; live_bits[3] = 1;
        live_bits[5] = 1; live_bits[6] = 1;
        run_pass(8, 640, 0, 0, "R4 mixed");
        // R5: whole frame dirty, flushed after last row
        set_bits(70, 1);
        run_pass(70, 800, 0, 0, "R5 all dirty");
        // clean frame: no regions
        set_bits(64, 0);
        run_pass(64, 320, 0, 0, "R9 clean");
        // alternating rows, last row dirty
        set_bits(40, 2);
        run_pass(40, 1024, 0, 0, "R4 alternating");
        // edges and a middle run
        set_bits(90, 3);
        run_pass(90, 1280, 0, 0, "R5 edges");
        // R2: dirty state was cleared by the snapshot, nothing new to report
        run_pass(90, 1280, 0, 0, "R2 cleared");
        // R7: full refresh ignores the bitmap
        set_bits(50, 2);
        run_pass(100, 1920, 1, 0, "R7 full");
        // R8: heavy output stall
        heavy_stall = 1;
        set_bits(120, 4);
        run_pass(120, 720, 0, 0, "R8 stall");
        heavy_stall = 0;
        // R5: single dirty row frame
        set_bits(1, 1);
        run_pass(1, 64, 0, 0, "R5 one row");
        // R9: zero height pass
        run_pass(0, 64, 0, 0, "R9 zero height");
        // R10: start while busy is ignored
        set_bits(200, 4);
        run_pass(200, 1600, 0, 1, "R10 restart");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule